// File: doc/BRIEF.md
# USART Baud Clock Generator

This block derives the bit-rate enables that a USART transmitter and receiver run from. A reloadable down-counter prescaler divides the system clock by a programmable divisor plus one. A short chain of binary divide stages follows the prescaler and supplies the slower transmit rates. In synchronous operation the block either drives a serial clock pin as master or follows an external serial clock as slave. In slave mode the external clock passes through a synchronizer and an edge detector. The detected edges then become single-cycle enables.

Three control bits select one of four modes: normal asynchronous, double-speed asynchronous, synchronous master and synchronous slave. A sync bit picks asynchronous or synchronous operation. A double-speed bit has an effect only in asynchronous operation. A direction bit picks master or slave in synchronous operation. A polarity bit decides which serial clock edge launches data and which edge samples it. All outputs are one-cycle enables in the system clock domain, so the shift logic downstream needs no second clock.

Top module: `usart_baud_gen`

## Requirements
- R1: While `rst_ni` is low, `tx_en_o`, `rx_en_o`, `edge_o`, `xck_o` and `xck_oe_o` are all 0, whatever the mode inputs are.
- R2: In either asynchronous mode (`sync_mode_i`=0), `rx_en_o` pulses for one cycle every D+1 cycles, where D is the divisor (0 to 4095 with the default width).
- R3: In normal asynchronous mode (`sync_mode_i`=0, `dbl_speed_i`=0), `tx_en_o` pulses every 16·(D+1) cycles, and only in a cycle where `rx_en_o` is also high.
- R4: In double-speed asynchronous mode (`sync_mode_i`=0, `dbl_speed_i`=1), `tx_en_o` pulses every 8·(D+1) cycles.
- R5: In synchronous master mode (`sync_mode_i`=1, `clk_dir_i`=1), `xck_oe_o` is 1. `xck_o` stays high for D+1 cycles and low for D+1 cycles. `tx_en_o` and `rx_en_o` each pulse every 2·(D+1) cycles. `dbl_speed_i` has no effect.
- R6: In synchronous master mode, `tx_en_o` and `rx_en_o` are never high together. `rx_en_o` follows each `tx_en_o` pulse after D+1 cycles. Each pulse falls in the cycle before `xck_o` toggles.
- R7: In synchronous slave mode (`sync_mode_i`=1, `clk_dir_i`=0), `xck_oe_o` and `xck_o` are 0. A change on `xck_i` applied before clock edge k yields a one-cycle enable in the cycle after edge k+1. With `clk_pol_i`=0, a rising edge gives `tx_en_o` and a falling edge gives `rx_en_o`. With `clk_pol_i`=1 the two are swapped.
- R8: A one-cycle `div_wr_i` reloads the prescaler from `divisor_i` at once. The first following `rx_en_o` in asynchronous mode comes D+1 cycles after the write cycle, and none comes earlier.
- R9: In asynchronous modes, `xck_oe_o`, `xck_o` and `edge_o` stay 0, and activity on `xck_i` does not change the `rx_en_o` pulse train.
- R10: In both synchronous modes, `edge_o` is high exactly in the cycles where `rx_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| divisor_i | input | DIV_W (12) | Baud divisor D; the prescaler divides by D+1 |
| div_wr_i | input | 1 | One-cycle strobe: reload the prescaler now |
| sync_mode_i | input | 1 | 0 asynchronous, 1 synchronous |
| dbl_speed_i | input | 1 | Double-speed select, used in asynchronous mode only |
| clk_dir_i | input | 1 | Synchronous only: 1 master (drive clock), 0 slave (follow pin) |
| clk_pol_i | input | 1 | Serial clock polarity: which edge launches and which samples |
| xck_i | input | 1 | External serial clock from the pin |
| xck_o | output | 1 | Serial clock driven in master mode |
| xck_oe_o | output | 1 | Output enable for the serial clock pin |
| tx_en_o | output | 1 | Transmitter clock enable |
| rx_en_o | output | 1 | Receiver base clock enable |
| edge_o | output | 1 | Sampling edge indication in synchronous modes |

## Verification
The bench builds the block with the default 12-bit divisor, two synchronizer stages and four divide stages. With these values a divisor of 4095 gives a full-range prescaler period of 4096 cycles, which the bench measures directly. The four divide stages bring the /2, /8 and /16 taps into reach, so the bench measures all three rates for both zero and non-zero divisors. The two-stage synchronizer fixes the slave edge-to-enable latency at two cycles, and the bench checks that latency for both polarities.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'd0,
    MODE_ASYNC_X2 = 2'd1,
    MODE_SYNC_MST = 2'd2,
    MODE_SYNC_SLV = 2'd3
  } ubg_mode_e;

  function automatic ubg_mode_e ubg_decode(input logic sync_sel,
                                           input logic dbl_sel,
                                           input logic dir_sel);
    ubg_mode_e m;
    if (!sync_sel) m = dbl_sel ? MODE_ASYNC_X2 : MODE_ASYNC;
    else           m = dir_sel ? MODE_SYNC_MST : MODE_SYNC_SLV;
    return m;
  endfunction

endpackage

// File: rtl/ubg_prescaler.sv
module ubg_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    if (load_i || at_zero) cnt_d = divisor_i;
    else                   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = at_zero;

endmodule

// File: rtl/ubg_divstage.sv
module ubg_divstage #(
  parameter int STG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [STG_W-1:0] cnt_o,
  output logic [STG_W-1:0] tap_o
);

  logic [STG_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)       cnt_d = '0;
    else if (step_i) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // tap i fires once every 2^(i+1) steps
  for (genvar i = 0; i < STG_W; i++) begin : g_tap
    assign tap_o[i] = step_i & (&cnt_q[i:0]);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ubg_xck_sync.sv
module ubg_xck_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xck_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_N-1:0] chain_q, chain_d;
  logic              hist_q, hist_d;
  logic              lvl;

  assign lvl = chain_q[SYNC_N-1];

  always_comb begin
    chain_d = {chain_q[SYNC_N-2:0], xck_i};
    hist_d  = lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      hist_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      hist_q  <= hist_d;
    end
  end

  assign rise_o = lvl & ~hist_q;
  assign fall_o = ~lvl & hist_q;

endmodule

// File: rtl/usart_baud_gen.sv
module usart_baud_gen #(
  parameter int DIV_W  = 12,
  parameter int SYNC_N = 2,
  parameter int STG_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             div_wr_i,
  input  logic             sync_mode_i,
  input  logic             dbl_speed_i,
  input  logic             clk_dir_i,
  input  logic             clk_pol_i,
  input  logic             xck_i,
  output logic             xck_o,
  output logic             xck_oe_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             edge_o
);
  import ubg_pkg::*;

  localparam int TAP_X2  = 2;        // /8 of prescaler
  localparam int TAP_STD = STG_W - 1; // /16 of prescaler

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign run = rst_pipe_q[1];

  ubg_mode_e mode;
  assign mode = ubg_decode(sync_mode_i, dbl_speed_i, clk_dir_i);

  logic             pre_tick, pre_en;
  logic [STG_W-1:0] div_cnt, div_tap;
  logic             xs_rise, xs_fall;

  ubg_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (run),
    .load_i    (div_wr_i),
    .divisor_i (divisor_i),
    .tick_o    (pre_tick)
  );

  assign pre_en = run & pre_tick;

  ubg_divstage #(.STG_W(STG_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (run),
    .clr_i  (div_wr_i),
    .step_i (pre_en),
    .cnt_o  (div_cnt),
    .tap_o  (div_tap)
  );

  ubg_xck_sync #(.SYNC_N(SYNC_N)) u_xs (
    .clk_i  (clk_i),
    .rst_ni (run),
    .xck_i  (xck_i),
    .rise_o (xs_rise),
    .fall_o (xs_fall)
  );

  logic mst_up, mst_dn;
  assign mst_up = pre_en & ~div_cnt[0];
  assign mst_dn = pre_en &  div_cnt[0];

  always_comb begin
    tx_en_o  = 1'b0;
    rx_en_o  = 1'b0;
    edge_o   = 1'b0;
    xck_o    = 1'b0;
    xck_oe_o = 1'b0;
    unique case (mode)
      MODE_ASYNC: begin
        tx_en_o = div_tap[TAP_STD];
        rx_en_o = pre_en;
      end
      MODE_ASYNC_X2: begin
        tx_en_o = div_tap[TAP_X2];
        rx_en_o = pre_en;
      end
      MODE_SYNC_MST: begin
        tx_en_o  = clk_pol_i ? mst_dn : mst_up;
        rx_en_o  = clk_pol_i ? mst_up : mst_dn;
        edge_o   = rx_en_o;
        xck_o    = run & div_cnt[0];
        xck_oe_o = run;
      end
      MODE_SYNC_SLV: begin
        tx_en_o = run & (clk_pol_i ? xs_fall : xs_rise);
        rx_en_o = run & (clk_pol_i ? xs_rise : xs_fall);
        edge_o  = rx_en_o;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ubg_checker.sv
module ubg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic div_wr_i,
  input logic sync_mode_i,
  input logic clk_dir_i,
  input logic clk_pol_i,
  input logic xck_o,
  input logic xck_oe_o,
  input logic tx_en_o,
  input logic rx_en_o,
  input logic edge_o
);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !(tx_en_o || rx_en_o || edge_o || xck_o || xck_oe_o));

  // R3
  a_r3_tx_on_prescale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_mode_i && tx_en_o) |-> rx_en_o);

  // R9
  a_r9_async_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_i |-> (!xck_oe_o && !xck_o && !edge_o));

  // R6
  a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |-> !(tx_en_o && rx_en_o));

  // R6
  a_r6_xck_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && clk_dir_i && !div_wr_i && (tx_en_o || rx_en_o))
      |=> (xck_o != $past(xck_o)) || !(sync_mode_i && clk_dir_i));

  // R7
  a_r7_slave_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !clk_dir_i && tx_en_o)
      |=> !tx_en_o || !(sync_mode_i && !clk_dir_i) || (clk_pol_i != $past(clk_pol_i)));

  // R7
  a_r7_slave_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_mode_i && !clk_dir_i) |-> (!xck_oe_o && !xck_o));

endmodule

bind usart_baud_gen ubg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .div_wr_i    (div_wr_i),
  .sync_mode_i (sync_mode_i),
  .clk_dir_i   (clk_dir_i),
  .clk_pol_i   (clk_pol_i),
  .xck_o       (xck_o),
  .xck_oe_o    (xck_oe_o),
  .tx_en_o     (tx_en_o),
  .rx_en_o     (rx_en_o),
  .edge_o      (edge_o)
);

// File: tb/usart_baud_gen_tb.sv
module usart_baud_gen_tb;
  localparam int DW = 12;
  localparam int LIM = 70000;

  logic          clk;
  logic          rst_n;
  logic [DW-1:0] divisor;
  logic          div_wr, sync_m, dbl, dir, pol, xck_in;
  logic          xck_out, xck_oe, tx_en, rx_en, edge_ind;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  usart_baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .divisor_i(divisor), .div_wr_i(div_wr),
    .sync_mode_i(sync_m), .dbl_speed_i(dbl), .clk_dir_i(dir), .clk_pol_i(pol),
    .xck_i(xck_in), .xck_o(xck_out), .xck_oe_o(xck_oe), .tx_en_o(tx_en),
    .rx_en_o(rx_en), .edge_o(edge_ind)
  );

  typedef struct packed {
    logic          s;
    logic          d;
    logic          m;
    logic [DW-1:0] dv;
    logic [19:0]   txp;
    logic [19:0]   rxp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 12'd3,  20'd64,  20'd4},   // R3 R2
    '{1'b0, 1'b1, 1'b0, 12'd3,  20'd32,  20'd4},   // R4
    '{1'b0, 1'b0, 1'b0, 12'd0,  20'd16,  20'd1},   // R3 zero divisor
    '{1'b0, 1'b1, 1'b0, 12'd0,  20'd8,   20'd1},   // R4 zero divisor
    '{1'b0, 1'b0, 1'b0, 12'd11, 20'd192, 20'd12},  // R3
    '{1'b1, 1'b0, 1'b1, 12'd2,  20'd6,   20'd6},   // R5
    '{1'b1, 1'b0, 1'b1, 12'd0,  20'd2,   20'd2},   // R5 zero divisor
    '{1'b1, 1'b1, 1'b1, 12'd1,  20'd4,   20'd4}    // R5 double-speed ignored
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic s, input logic d, input logic m,
                           input logic p, input logic [DW-1:0] dv);
    @(negedge clk);
    sync_m = s; dbl = d; dir = m; pol = p; divisor = dv; div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic gap(input bit use_rx, output int g);
    g = -1;
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk);
      if (use_rx ? rx_en : tx_en) break;
    end
    for (int i = 1; i < LIM; i++) begin
      @(negedge clk);
      if (use_rx ? rx_en : tx_en) begin g = i; break; end
    end
  endtask

  task automatic slave_edge(input logic lvl, output int first_tx, output int first_rx,
                            output int ntx, output int nrx, output int nedge_bad);
    first_tx = -1; first_rx = -1; ntx = 0; nrx = 0; nedge_bad = 0;
    xck_in = lvl;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (tx_en) begin ntx++; if (first_tx < 0) first_tx = n; end
      if (rx_en) begin nrx++; if (first_rx < 0) first_rx = n; end
      if (edge_ind != rx_en) nedge_bad++;
      if (xck_oe || xck_out) nedge_bad++;
    end
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int g, ft, fr, nt, nr, nb, hi, cnt, bad;
    rst_n = 1'b0; divisor = '0; div_wr = 1'b0;
    sync_m = 1'b1; dbl = 1'b0; dir = 1'b1; pol = 1'b0; xck_in = 1'b0;

    // R1: reset state with master mode selected
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tx_en || rx_en || edge_ind || xck_out || xck_oe) bad++;
    end
    chk(bad == 0, "R1 outputs quiet in reset", bad, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R2 R3 R4 R5
    foreach (VECS[k]) begin
      configure(VECS[k].s, VECS[k].d, VECS[k].m, 1'b0, VECS[k].dv);
      gap(1'b0, g);
      chk(g == int'(VECS[k].txp), "R3/R4/R5 tx period", g, int'(VECS[k].txp));
      gap(1'b1, g);
      chk(g == int'(VECS[k].rxp), "R2/R5 rx period", g, int'(VECS[k].rxp));
      chk(xck_oe == (VECS[k].s & VECS[k].m), "R5/R9 pin enable", xck_oe,
          VECS[k].s & VECS[k].m);
    end

    // R2: full-range divisor
    configure(1'b0, 1'b0, 1'b0, 1'b0, 12'd4095);
    gap(1'b1, g);
    chk(g == 4096, "R2 max divisor rx period", g, 4096);

    // R5 R6 R10: master phase and clock shape, D=2
    configure(1'b1, 1'b0, 1'b1, 1'b0, 12'd2);
    while (xck_out !== 1'b0) @(negedge clk);
    while (xck_out !== 1'b1) @(negedge clk);
    hi = 0;
    while (xck_out === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    chk(hi == 3, "R5 xck high phase", hi, 3);
    while (!tx_en) @(negedge clk);
    cnt = 0;
    bad = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (tx_en) bad++;
    end while (!rx_en && cnt < 100);
    chk(cnt == 3, "R6 rx follows tx", cnt, 3);
    chk(bad == 0, "R6 no second tx before rx", bad, 0);
    chk(edge_ind == 1'b1, "R10 edge with rx in master", edge_ind, 1);

    // R8: divisor write reloads at once
    configure(1'b0, 1'b0, 1'b0, 1'b0, 12'd3);
    repeat (7) @(negedge clk);
    divisor = 12'd9; div_wr = 1'b1;
    cnt = -1;
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      div_wr = 1'b0;
      if (rx_en && cnt < 0) cnt = n;
    end
    chk(cnt == 10, "R8 first rx after reload", cnt, 10);

    // R9: async ignores external clock
    configure(1'b0, 1'b0, 1'b0, 1'b0, 12'd3);
    @(negedge clk);
    cnt = 0; bad = 0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      xck_in = ~xck_in;
      if (rx_en) cnt++;
      if (xck_oe || xck_out || edge_ind) bad++;
    end
    chk(cnt == 10, "R9 rx train with xck toggling", cnt, 10);
    chk(bad == 0, "R9 pin and edge quiet", bad, 0);

    // R7 R10: slave, polarity 0
    xck_in = 1'b0;
    configure(1'b1, 1'b0, 1'b0, 1'b0, 12'd5);
    repeat (4) @(negedge clk);
    slave_edge(1'b1, ft, fr, nt, nr, nb);
    chk(ft == 2, "R7 rise->tx latency", ft, 2);
    chk(nt == 1, "R7 tx single cycle", nt, 1);
    chk(nr == 0, "R7 no rx on rise pol0", nr, 0);
    chk(nb == 0, "R7/R10 slave pin and edge", nb, 0);
    slave_edge(1'b0, ft, fr, nt, nr, nb);
    chk(fr == 2, "R7 fall->rx latency", fr, 2);
    chk(nr == 1 && nt == 0, "R7 fall gives only rx", nr * 10 + nt, 10);
    chk(nb == 0, "R10 edge tracks rx in slave", nb, 0);

    // R7: slave, polarity 1 swaps roles
    @(negedge clk);
    pol = 1'b1;
    repeat (3) @(negedge clk);
    slave_edge(1'b1, ft, fr, nt, nr, nb);
    chk(fr == 2 && nt == 0, "R7 pol1 rise->rx", fr * 10 + nt, 20);
    slave_edge(1'b0, ft, fr, nt, nr, nb);
    chk(ft == 2 && nr == 0, "R7 pol1 fall->tx", ft * 10 + nr, 20);

    // R1: reset asserted mid-run
    configure(1'b1, 1'b0, 1'b1, 1'b0, 12'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!(tx_en || rx_en || xck_oe || xck_out || edge_ind), "R1 async reset clears outputs",
        {tx_en, rx_en, xck_oe, xck_out, edge_ind}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule